// File: doc/BRIEF.md
# Serial EEPROM Target with One-Time Write Lock

This block is a two-wire serial bus target that behaves like a 256-byte EEPROM with one-byte word addressing. It runs on a system clock and oversamples the bus clock and data lines. It finds START, repeated START and STOP conditions on the synchronized lines. It drives the data line only as an open-drain pull-down, through an output enable.

The memory answers at one 7-bit address in the range 0x50 to 0x57. Three strap inputs choose the low bits. A companion lock address sits 0x20 lower, in the range 0x30 to 0x37, with the same strap bits. A write-direction probe to the lock address is acknowledged. The first data byte sent to it sets a lock flag that only reset can clear. The lock freezes the lower half of the array and takes the lock address off the bus for good.

Transfers supported are byte and page-style write, current-address read, random read (pointer write, repeated START, read), and sequential read, which runs until the controller answers a byte with NACK.

Top module: `seeprom_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0x50 plus the strap value is acknowledged in both directions (direction bit 0 = write, 1 = read). Any other address, such as 0x50 with strap 5, gets no acknowledge.
- R2: In a write transfer to the memory, the first data byte loads the word pointer. Each later byte is stored at the pointer, and every byte is acknowledged.
- R3: The word pointer steps by one after each byte stored or read, and wraps from 0xFF to 0x00.
- R4: A read transfer returns bytes from the current pointer, MSB first. Reading continues while the controller acknowledges. After a NACK the line stays released.
- R5: A pointer write followed by a repeated START and a read address returns data from the newly written pointer.
- R6: Before locking, the lock address (memory address minus 0x20) acknowledges a write-direction address with no data and changes nothing. A read-direction address to it is not acknowledged.
- R7: Any data byte written to the lock address is acknowledged and sets the lock. After that, the lock address is not acknowledged in either direction, and the lock stays set until reset.
- R8: While locked, writes to locations 0x00–0x7F are acknowledged but leave the array unchanged. Locations 0x80–0xFF stay writable.
- R9: The target never drives the data line during a bit the controller drives (address bits, write data bits, read acknowledge bits).
- R10: After reset the data line is released, every array byte reads 0xFF, and the pointer is 0x00.
- R11: A STOP releases the line. A START in the middle of a byte abandons that byte and begins a new address phase without moving the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; clears the lock and the pointer and fills the array with 0xFF |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| strap_i | input | 3 | Low three bits of both target addresses |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume one controller on the bus. They assume the data line changes only while the bus clock is low, except for START and STOP. They also assume each bus-clock level lasts longer than the synchronizer depth plus two system clocks, so every edge and condition is seen exactly once. The bench keeps within this by holding each quarter of a bus bit for eight system clocks. It moves the data line only in the low phase, or in the dedicated START and STOP sequences. It models the wired-AND line as its own drive ANDed with the inverted output enable.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CNT_W     = $clog2(BYTE_W);
    localparam int unsigned STRAP_W   = 3;
    localparam int unsigned DEV_W     = 7;
    localparam logic [DEV_W-1:0] MEM_BASE = 7'h50;
    localparam logic [DEV_W-1:0] LOCK_GAP = 7'h20;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_e;

    typedef enum logic [1:0] {
        TG_NONE,
        TG_MEM,
        TG_LOCK
    } target_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [DEV_W-1:0] mem_dev(input logic [STRAP_W-1:0] strap);
        return MEM_BASE | {{(DEV_W-STRAP_W){1'b0}}, strap};
    endfunction

    function automatic logic [DEV_W-1:0] lock_dev(input logic [STRAP_W-1:0] strap);
        return mem_dev(strap) - LOCK_GAP;
    endfunction

endpackage

// File: rtl/seeprom_linesync.sv
module seeprom_linesync
    import seeprom_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev_o.sda      = sda_s;
    end
endmodule

// File: rtl/seeprom_store.sv
module seeprom_store
    import seeprom_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              lock_set,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata,
    output logic              locked
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [BYTE_W-1:0] cells [DEPTH];
    logic              low_half;

    assign low_half = ~waddr[AW-1];
    assign rdata    = cells[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else begin
            if (lock_set) locked <= 1'b1;
            if (we && !(locked && low_half)) cells[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
    import seeprom_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic               locked,
    input  logic [BYTE_W-1:0]  rdata,
    output logic [AW-1:0]      ptr_o,
    output logic               we_o,
    output logic [AW-1:0]      waddr_o,
    output logic [BYTE_W-1:0]  wdata_o,
    output logic               lock_set_o,
    output logic               ptr_load_o,
    output target_e            tgt_o,
    output logic               sda_oe_o
);
    phase_e            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_full, rd_dir, first_data;
    logic [DEV_W-1:0]  hdr_dev;
    logic              hdr_rd;

    assign hdr_dev = shreg[BYTE_W-1:1];
    assign hdr_rd  = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            byte_full  <= 1'b0;
            rd_dir     <= 1'b0;
            first_data <= 1'b0;
            ptr_o      <= '0;
            we_o       <= 1'b0;
            waddr_o    <= '0;
            wdata_o    <= '0;
            lock_set_o <= 1'b0;
            ptr_load_o <= 1'b0;
            tgt_o      <= TG_NONE;
            sda_oe_o   <= 1'b0;
        end else begin
            we_o       <= 1'b0;
            lock_set_o <= 1'b0;
            ptr_load_o <= 1'b0;
            if (ev.start) begin
                phase     <= PH_ADDR;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                tgt_o     <= TG_NONE;
                sda_oe_o  <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                tgt_o    <= TG_NONE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_WR: begin
                        if (ev.scl_rise) begin
                            shreg     <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt    <= bitcnt + 1'b1;
                            byte_full <= (bitcnt == CNT_W'(BYTE_W-1));
                        end else if (ev.scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (phase == PH_ADDR) begin
                                rd_dir     <= hdr_rd;
                                first_data <= 1'b1;
                                if (hdr_dev == mem_dev(strap)) begin
                                    tgt_o    <= TG_MEM;
                                    sda_oe_o <= 1'b1;
                                    phase    <= PH_ADDR_ACK;
                                end else if (hdr_dev == lock_dev(strap) && !hdr_rd && !locked) begin
                                    tgt_o    <= TG_LOCK;
                                    sda_oe_o <= 1'b1;
                                    phase    <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                sda_oe_o <= 1'b1;
                                phase    <= PH_WR_ACK;
                                if (tgt_o == TG_LOCK) begin
                                    lock_set_o <= 1'b1;
                                end else if (first_data) begin
                                    ptr_o      <= shreg[AW-1:0];
                                    ptr_load_o <= 1'b1;
                                    first_data <= 1'b0;
                                end else begin
                                    we_o    <= 1'b1;
                                    waddr_o <= ptr_o;
                                    wdata_o <= shreg;
                                    ptr_o   <= ptr_o + 1'b1;
                                end
                            end
                        end
                    end
                    PH_ADDR_ACK, PH_WR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR_ACK && rd_dir) begin
                                shreg    <= rdata;
                                sda_oe_o <= ~rdata[BYTE_W-1];
                                ptr_o    <= ptr_o + 1'b1;
                                phase    <= PH_RD;
                            end else begin
                                sda_oe_o <= 1'b0;
                                phase    <= PH_WR;
                            end
                        end
                    end
                    PH_RD: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == CNT_W'(BYTE_W-1)) begin
                                sda_oe_o <= 1'b0;
                                phase    <= PH_RD_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_RD_ACK: begin
                        if (ev.scl_rise && ev.sda) begin
                            phase <= PH_IDLE;
                        end else if (ev.scl_fall) begin
                            shreg    <= rdata;
                            sda_oe_o <= ~rdata[BYTE_W-1];
                            ptr_o    <= ptr_o + 1'b1;
                            bitcnt   <= '0;
                            phase    <= PH_RD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
    import seeprom_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o
);
    bus_ev_t           bus_ev;
    logic              ev_start, ev_stop;
    logic [AW-1:0]     ptr;
    logic              we, lock_set, locked, ptr_load;
    logic [AW-1:0]     waddr;
    logic [BYTE_W-1:0] wdata, rdata;
    target_e           tgt;

    assign ev_start = bus_ev.start;
    assign ev_stop  = bus_ev.stop;

    seeprom_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (bus_ev)
    );

    seeprom_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (bus_ev),
        .strap      (strap_i),
        .locked     (locked),
        .rdata      (rdata),
        .ptr_o      (ptr),
        .we_o       (we),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .lock_set_o (lock_set),
        .ptr_load_o (ptr_load),
        .tgt_o      (tgt),
        .sda_oe_o   (sda_oe_o)
    );

    seeprom_store #(.AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .lock_set (lock_set),
        .raddr    (ptr),
        .rdata    (rdata),
        .locked   (locked)
    );
endmodule

// File: rtl/seeprom_target_chk.sv
module seeprom_target_chk
    import seeprom_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          sda_oe,
    input logic          locked,
    input target_e       tgt,
    input logic [AW-1:0] ptr,
    input logic          ptr_load
);
    // R11: a START hands the line back to the controller
    a_r11_start_frees_line: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !sda_oe);

    // R11: a STOP hands the line back to the controller
    a_r11_stop_frees_line: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe);

    // R7: once set, the lock stays set
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R7: the lock address is never selected after locking
    a_r7_lock_addr_silent: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt == TG_LOCK) |-> !$past(locked));

    // R3: the pointer moves only by a load or a single step with wrap
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> (ptr_load || (ptr == $past(ptr) + 1'b1)));
endmodule

bind seeprom_target seeprom_target_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .sda_oe   (sda_oe_o),
    .locked   (locked),
    .tgt      (tgt),
    .ptr      (ptr),
    .ptr_load (ptr_load)
);

// File: tb/seeprom_target_bench.sv
module seeprom_target_bench;
    localparam int Q       = 8;
    localparam int WD_LIM  = 150000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MEM_A = 7'h55;
    localparam logic [6:0] LCK_A = 7'h35;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_ctl = 1'b1;
    logic sda_ctl = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit chk_rel = 1'b0;

    int mdl_mem [256];
    int mdl_ptr;
    bit mdl_lock;
    int mdl_tgt;
    bit mdl_first;

    always #5 clk = ~clk;

    assign sda_bus = sda_ctl & ~sda_oe;

    seeprom_target u_seeprom_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_ctl),
        .sda_i    (sda_bus),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R9: compared on every clock while the controller drives a bit
    always @(negedge clk) begin
        cyc++;
        if (chk_rel) chk("R9 line released in controller bit", int'(sda_oe), 0);
        if (cyc == WD_LIM && !done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctl = 1'b1; quarter();
        scl_ctl = 1'b1; quarter();
        sda_ctl = 1'b0; quarter();
        scl_ctl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_ctl = 1'b0; quarter();
        scl_ctl = 1'b1; quarter();
        sda_ctl = 1'b1; quarter();
    endtask

    task automatic send_bit(input bit b);
        sda_ctl = b; quarter();
        scl_ctl = 1'b1; chk_rel = 1'b1; quarter();
        quarter();
        chk_rel = 1'b0; scl_ctl = 1'b0; quarter();
    endtask

    task automatic recv_bit(output bit b);
        sda_ctl = 1'b1; quarter();
        scl_ctl = 1'b1; quarter();
        b = sda_bus; quarter();
        scl_ctl = 1'b0; quarter();
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = !x;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(!ack);
    endtask

    task automatic tx_start();
        bus_start();
        mdl_tgt = 0;
    endtask

    task automatic tx_stop();
        bus_stop();
        mdl_tgt = 0;
    endtask

    task automatic tx_addr(input logic [6:0] a, input bit rd, input string tag);
        bit ack;
        int exp;
        exp = (a == MEM_A) ? 1 : ((a == LCK_A && !rd && !mdl_lock) ? 1 : 0);
        write_byte({a, rd}, ack);
        chk(tag, int'(ack), exp);
        mdl_tgt = (exp == 0) ? 0 : ((a == MEM_A) ? 1 : 2);
        mdl_first = 1'b1;
    endtask

    task automatic tx_data(input logic [7:0] d, input string tag);
        bit ack;
        write_byte(d, ack);
        chk(tag, int'(ack), (mdl_tgt != 0) ? 1 : 0);
        if (mdl_tgt == 2) begin
            mdl_lock = 1'b1;
        end else if (mdl_tgt == 1) begin
            if (mdl_first) begin
                mdl_ptr = int'(d);
                mdl_first = 1'b0;
            end else begin
                if (!(mdl_lock && mdl_ptr < 128)) mdl_mem[mdl_ptr] = int'(d);
                mdl_ptr = (mdl_ptr + 1) % 256;
            end
        end
    endtask

    task automatic rx_data(input bit last, input string tag);
        logic [7:0] v;
        read_byte(v, !last);
        chk(tag, int'(v), mdl_mem[mdl_ptr]);
        mdl_ptr = (mdl_ptr + 1) % 256;
    endtask

    task automatic set_ptr_read(input logic [7:0] p, input int n, input string tag);
        tx_start();
        tx_addr(MEM_A, 1'b0, tag);
        tx_data(p, tag);
        tx_start();
        tx_addr(MEM_A, 1'b1, tag);
        for (int i = 0; i < n; i++) rx_data(i == n - 1, tag);
        tx_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'hFF;
        mdl_ptr = 0;
        mdl_lock = 1'b0;
        mdl_tgt = 0;
        mdl_first = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 line released in reset", int'(sda_oe), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 line released after reset", int'(sda_oe), 0);

        // R10 / R4: current-address read from pointer 0 after reset
        tx_start();
        tx_addr(MEM_A, 1'b1, "R1 memory read address");
        rx_data(1'b0, "R10 erased byte");
        rx_data(1'b1, "R4 sequential erased byte");
        tx_stop();
        chk("R4 released after nack", int'(sda_oe), 0);

        // R1: foreign addresses are not acknowledged
        tx_start();
        tx_addr(7'h50, 1'b0, "R1 other strap no ack");
        tx_stop();
        tx_start();
        tx_addr(7'h57, 1'b1, "R1 other strap read no ack");
        tx_stop();

        // R2: pointer load then stored bytes
        tx_start();
        tx_addr(MEM_A, 1'b0, "R2 write address");
        tx_data(8'h10, "R2 pointer byte");
        tx_data(8'hA1, "R2 data byte");
        tx_data(8'hB2, "R2 data byte");
        tx_data(8'hC3, "R2 data byte");
        tx_stop();

        // R5: random read of the written bytes
        set_ptr_read(8'h10, 3, "R5 random read");
        // R4: current-address read continues at 0x13
        tx_start();
        tx_addr(MEM_A, 1'b1, "R4 current read address");
        rx_data(1'b1, "R4 current read");
        tx_stop();

        // R3: wrap from 0xFF to 0x00
        tx_start();
        tx_addr(MEM_A, 1'b0, "R3 write address");
        tx_data(8'hFE, "R3 pointer byte");
        tx_data(8'h11, "R3 data");
        tx_data(8'h22, "R3 data");
        tx_data(8'h33, "R3 wrapped data");
        tx_stop();
        set_ptr_read(8'hFE, 4, "R3 read across wrap");

        // R11: START inside a byte restarts the address phase
        tx_start();
        tx_addr(MEM_A, 1'b0, "R11 write address");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        tx_start();
        tx_addr(MEM_A, 1'b1, "R11 restart read address");
        rx_data(1'b1, "R11 pointer kept after restart");
        tx_stop();

        // R6: lock address probe behaviour
        tx_start();
        tx_addr(LCK_A, 1'b1, "R6 lock read no ack");
        tx_stop();
        tx_start();
        tx_addr(LCK_A, 1'b0, "R6 quick write ack");
        tx_stop();
        tx_start();
        tx_addr(MEM_A, 1'b0, "R6 write after probe");
        tx_data(8'h05, "R6 pointer");
        tx_data(8'h5A, "R6 low half still writable");
        tx_stop();
        set_ptr_read(8'h05, 1, "R6 low write landed");

        // R7: data byte to lock address sets the lock
        tx_start();
        tx_addr(LCK_A, 1'b0, "R7 lock address");
        tx_data(8'h00, "R7 lock data ack");
        tx_stop();
        tx_start();
        tx_addr(LCK_A, 1'b0, "R7 lock address write silent");
        tx_stop();
        tx_start();
        tx_addr(LCK_A, 1'b1, "R7 lock address read silent");
        tx_stop();

        // R8: protected lower half, writable upper half
        tx_start();
        tx_addr(MEM_A, 1'b0, "R8 write address");
        tx_data(8'h05, "R8 pointer");
        tx_data(8'h77, "R8 low write acked");
        tx_stop();
        set_ptr_read(8'h05, 1, "R8 low byte unchanged");
        tx_start();
        tx_addr(MEM_A, 1'b0, "R8 write address");
        tx_data(8'h7F, "R8 pointer at boundary");
        tx_data(8'h01, "R8 0x7F acked");
        tx_data(8'h02, "R8 0x80 acked");
        tx_data(8'h99, "R8 0x81 acked");
        tx_stop();
        set_ptr_read(8'h7F, 3, "R8 boundary readback");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule